// File: doc/BRIEF.md
# Paged-Register I2C Target

This block is an I2C target that lets a host reach a register space split into sparse pages. The host addresses the block with a 7-bit address whose five upper bits are fixed and whose two lower bits come from strap inputs. It then writes a subaddress byte and either writes data bytes or, after a repeated START with the read bit set, reads them back. A page register at subaddress FFh keeps its value between transactions. It steers every other subaddress onto the page it holds.

Toward the device logic the block drives a plain register bus. The bus carries the current page, the current offset, write data and a one-cycle write strobe. The device logic answers with read data and a flag that says whether the addressed register may be read. Reads of registers flagged as unreadable return 00h. Reads on a page outside the valid list also return 00h, and writes there are dropped. The bus lines pass through a two-flop synchronizer and are sampled by the system clock. SCL is an input only. SDA is only ever pulled low.

The controller moves through these states. ST_IDLE waits for a START. ST_ADDR shifts in the address byte. ST_ADDR_ACK acknowledges a match. ST_SUB shifts in the subaddress, and ST_SUB_ACK acknowledges it. ST_WDATA and ST_WDATA_ACK shift in each data byte and acknowledge it. ST_RDATA shifts out a byte. ST_RACK samples the host's acknowledge.

The transitions are:
- START from any state goes to ST_ADDR, and STOP from any state goes to ST_IDLE.
- At the end of the address byte, a match goes to ST_ADDR_ACK and a miss goes to ST_IDLE.
- ST_ADDR_ACK goes to ST_RDATA for a read and to ST_SUB for a write.
- Each byte state goes to its acknowledge state after eight bits.
- ST_SUB_ACK and ST_WDATA_ACK go to ST_WDATA.
- ST_RACK goes to ST_RDATA on ACK and to ST_IDLE on NACK.

Top module: `pgreg_i2c_target`

## Requirements
- R1: The block acknowledges (pulls SDA low during the ninth clock) only an address byte whose bits 7..3 are 11100 and whose bits 2..1 equal strap_i[1:0]. Bit 0 is R/W, with 0 for write. Any other address gets no acknowledge, and SDA stays released until the next START.
- R2: SDA is never actively driven high. sda_oe only turns on while synchronized SCL is low.
- R3: In a write (START, address with R/W=0, subaddress, data bytes, STOP), each data byte to a subaddress other than FFh on a valid page gives exactly one single-cycle reg_wr pulse. The pulse carries reg_page, reg_offset equal to the current subaddress, and reg_wdata equal to the byte. Every data byte is acknowledged.
- R4: The page register resets to 00h. A data byte written to subaddress FFh loads it, on any page. It keeps its value across transactions, drives reg_page, and reads back at subaddress FFh.
- R5: The valid pages are 00h, 01h, 02h, 09h, 10h, 11h and 12h. On any other page, writes to subaddresses other than FFh produce no reg_wr but are still acknowledged, and reads return 00h.
- R6: A read is the subaddress write, then a repeated START with R/W=1. Data bytes are sent MSB first from the current subaddress until the host NACKs. After the NACK, SDA is released.
- R7: The subaddress advances by one after every data byte, in both directions. It wraps from FEh to 00h, and FFh also advances to 00h. Auto-increment therefore never lands on FFh.
- R8: A read of a register whose reg_readable is 0 returns 00h. The address and subaddress bytes are still acknowledged.
- R9: A START or STOP at any bit position aborts the current byte with no write. A STOP returns the block to idle. A START begins a new address phase.
- R10: The block works for SCL low and high phases of at least six system clocks each, and so covers both a slow and a fast bus rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line (never driven) |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_i | input | 2 | Strap pins giving address bits 1..0 |
| reg_page | output | 8 | Current page register |
| reg_offset | output | 8 | Current subaddress |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data for reg_page/reg_offset |
| reg_readable | input | 1 | 1 when the addressed register may be read |

## Verification
One data byte can both change the page register and decide where the very next byte lands. A burst that starts at FFh writes the page and then auto-increments to 00h, which must already use the new page. The bench provokes this with a write burst that starts at FFh followed by a data byte. The reference model queues the expected page, offset and data, and every strobe is compared against the queue on the clock where it appears. A second case, a burst starting at FDh, checks that the FEh-to-00h wrap skips the page register while the page stays unchanged.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } tgt_state_t;

    localparam logic [4:0] TGT_ADDR_HI = 5'b11100;
    localparam logic [7:0] PAGE_SUB    = 8'hFF;
    localparam logic [7:0] LAST_SUB    = 8'hFE;

    function automatic logic [7:0] next_sub(input logic [7:0] s);
        if (s == LAST_SUB || s == PAGE_SUB) return 8'h00;
        return s + 8'h01;
    endfunction

endpackage

// File: rtl/pgreg_line_sync.sv
module pgreg_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= RST_VAL;
                else if (g == 0) chain_q[g] <= din;
                else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pgreg_cond_det.sv
module pgreg_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/pgreg_page_map.sv
module pgreg_page_map #(
    parameter int                         NUM_PAGES = 7,
    parameter logic [NUM_PAGES*8-1:0]     PAGE_LIST = {8'h12, 8'h11, 8'h10, 8'h09, 8'h02, 8'h01, 8'h00}
) (
    input  logic [7:0] page,
    output logic       page_ok
);
    logic [NUM_PAGES-1:0] hit;

    generate
        for (genvar g = 0; g < NUM_PAGES; g++) begin : g_pg
            assign hit[g] = (page == PAGE_LIST[g*8 +: 8]);
        end
    endgenerate

    assign page_ok = |hit;
endmodule

// File: rtl/pgreg_i2c_target.sv
module pgreg_i2c_target
    import pgreg_pkg::*;
#(
    parameter int                     SYNC_STAGES = 2,
    parameter int                     NUM_PAGES   = 7,
    parameter logic [NUM_PAGES*8-1:0] PAGE_LIST   = {8'h12, 8'h11, 8'h10, 8'h09, 8'h02, 8'h01, 8'h00}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] strap_i,
    output logic [7:0] reg_page,
    output logic [7:0] reg_offset,
    output logic [7:0] reg_wdata,
    output logic       reg_wr,
    input  logic [7:0] reg_rdata,
    input  logic       reg_readable
);
    localparam int BITS_PER_BYTE = 8;
    localparam int CNT_W         = $clog2(BITS_PER_BYTE + 1);

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic page_ok;

    tgt_state_t       state_q, state_d;
    logic [7:0]       shreg, sub_q, page_q, rd_val;
    logic [CNT_W-1:0] cnt;
    logic             rw_q, nack_q, wr_q;
    logic             byte_done, addr_hit;

    pgreg_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_s));
    pgreg_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_s));

    pgreg_cond_det u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det));

    pgreg_page_map #(.NUM_PAGES(NUM_PAGES), .PAGE_LIST(PAGE_LIST)) u_map (
        .page(page_q), .page_ok(page_ok));

    assign byte_done = (cnt == CNT_W'(BITS_PER_BYTE));
    assign addr_hit  = (shreg[7:1] == {TGT_ADDR_HI, strap_i});
    assign rd_val    = (sub_q == PAGE_SUB)          ? page_q    :
                       (page_ok && reg_readable)    ? reg_rdata : 8'h00;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (scl_fall && byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall) state_d = rw_q ? ST_RDATA : ST_SUB;
                ST_SUB:       if (scl_fall && byte_done) state_d = ST_SUB_ACK;
                ST_SUB_ACK:   if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && byte_done) state_d = ST_RACK;
                ST_RACK:      if (scl_fall) state_d = nack_q ? ST_IDLE : ST_RDATA;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath: shifter, bit count, subaddress, page register, strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= 8'h00;
            cnt    <= '0;
            sub_q  <= 8'h00;
            page_q <= 8'h00;
            rw_q   <= 1'b0;
            nack_q <= 1'b0;
            wr_q   <= 1'b0;
        end else begin
            wr_q <= 1'b0;
            if (start_det || stop_det) begin
                cnt <= '0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_SUB, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && byte_done) begin
                            cnt <= '0;
                            if (state_q == ST_ADDR)     rw_q   <= shreg[0];
                            else if (state_q == ST_SUB) sub_q  <= shreg;
                            else if (sub_q == PAGE_SUB) page_q <= shreg;
                            else                        wr_q   <= page_ok;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall && rw_q) begin
                            shreg <= rd_val;
                            cnt   <= '0;
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall) sub_q <= next_sub(sub_q);
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (byte_done) begin
                                cnt   <= '0;
                                sub_q <= next_sub(sub_q);
                            end else begin
                                shreg <= {shreg[6:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) nack_q <= sda_s;
                        else if (scl_fall && !nack_q) shreg <= rd_val;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_SUB_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~shreg[7];
            default:                               sda_oe = 1'b0;
        endcase
    end

    assign reg_page   = page_q;
    assign reg_offset = sub_q;
    assign reg_wdata  = shreg;
    assign reg_wr     = wr_q;

    // R2
    sda_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R3
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R5
    wr_valid_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> page_ok);

    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_q != $past(page_q)) |-> ($past(sub_q) == PAGE_SUB));

    // R9
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_ADDR && !sda_oe));

endmodule

// File: tb/sim_pgreg_i2c_target.sv
module sim_pgreg_i2c_target;
    localparam int         CLK_PERIOD = 10;
    localparam logic [4:0] DEV_HI     = 5'b11100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic [1:0] strap   = 2'b10;
    logic       sda_oe, sda_line, reg_wr, reg_readable;
    logic [7:0] reg_page, reg_offset, reg_wdata, reg_rdata;

    assign sda_line     = sda_drv & ~sda_oe;
    assign reg_rdata    = {reg_page[3:0], 4'h0} ^ reg_offset ^ 8'h3C;
    assign reg_readable = (reg_offset[7:4] != 4'hF);

    pgreg_i2c_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(strap), .reg_page(reg_page),
        .reg_offset(reg_offset), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rdata(reg_rdata), .reg_readable(reg_readable));

    int nvec = 0;
    int nerr = 0;
    int q = 10;
    int m_page = 0;
    logic [23:0] exp_wr[$];
    logic [23:0] mon_e;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic bit pvalid(input int p);
        return p == 8'h00 || p == 8'h01 || p == 8'h02 || p == 8'h09 ||
               p == 8'h10 || p == 8'h11 || p == 8'h12;
    endfunction

    function automatic int nsub(input int s);
        return (s >= 254) ? 0 : s + 1;
    endfunction

    function automatic int exp_rd(input int p, input int s);
        if (s == 255) return p;
        if (!pvalid(p) || s >= 8'hF0) return 0;
        return (((p & 15) << 4) ^ s ^ 8'h3C) & 255;
    endfunction

    // Reference check of every write strobe, on every clock.
    always @(negedge clk) begin
        if (rst_n && reg_wr) begin
            nvec++;
            if (exp_wr.size() == 0) begin
                nerr++;
                $display("FAIL R5 unexpected write act=%0h exp=none", {reg_page, reg_offset, reg_wdata});
            end else begin
                mon_e = exp_wr.pop_front();
                if ({reg_page, reg_offset, reg_wdata} != mon_e) begin
                    nerr++;
                    $display("FAIL R3 write act=%0h exp=%0h", {reg_page, reg_offset, reg_wdata}, mon_e);
                end
            end
        end
    end

    task automatic bus_start();
        sda_drv = 1'b1; tick(q);
        scl_drv = 1'b1; tick(q);
        sda_drv = 1'b0; tick(q);
        scl_drv = 1'b0; tick(q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick(q);
        scl_drv = 1'b1; tick(q);
        sda_drv = 1'b1; tick(2*q);
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b; tick(q);
        scl_drv = 1'b1; tick(2*q);
        scl_drv = 1'b0; tick(q);
    endtask

    task automatic recv_bit(output logic b);
        sda_drv = 1'b1; tick(q);
        scl_drv = 1'b1; tick(q);
        b = sda_line; tick(q);
        scl_drv = 1'b0; tick(q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(ack);
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(nack);
    endtask

    task automatic wr_burst(input int sub, input int n, input logic [31:0] bytes, input string req);
        logic ack;
        int s;
        logic [7:0] d;
        bus_start();
        send_byte({DEV_HI, strap, 1'b0}, ack); chk("R1 addr ack", ack, 0);
        send_byte(sub[7:0], ack);              chk("R3 sub ack", ack, 0);
        s = sub;
        for (int i = 0; i < n; i++) begin
            d = bytes[8*i +: 8];
            if (s == 255) m_page = d;
            else if (pvalid(m_page)) exp_wr.push_back({m_page[7:0], s[7:0], d});
            send_byte(d, ack);
            chk({req, " data ack"}, ack, 0);
            s = nsub(s);
        end
        bus_stop();
        tick(10);
    endtask

    task automatic rd_burst(input int sub, input int n, input string req);
        logic ack;
        int s;
        logic [7:0] d;
        bus_start();
        send_byte({DEV_HI, strap, 1'b0}, ack); chk("R1 addr ack", ack, 0);
        send_byte(sub[7:0], ack);              chk("R8 sub ack", ack, 0);
        bus_start();
        send_byte({DEV_HI, strap, 1'b1}, ack); chk("R6 read addr ack", ack, 0);
        s = sub;
        for (int i = 0; i < n; i++) begin
            recv_byte(d, (i == n-1));
            chk(req, d, exp_rd(m_page, s));
            s = nsub(s);
        end
        chk("R6 released after nack", sda_oe, 0);
        bus_stop();
        tick(10);
    endtask

    initial begin
        logic ack;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        chk("R2 reset sda_oe", sda_oe, 0);
        chk("R4 reset page", reg_page, 0);
        chk("R3 reset reg_wr", reg_wr, 0);

        // R1: wrong strap bits get no acknowledge
        bus_start();
        send_byte({DEV_HI, 2'b01, 1'b0}, ack);
        chk("R1 mismatch nack", ack, 1);
        bus_stop();
        tick(10);

        // R3 / R6: plain write and read back on page 00h
        wr_burst(8'h10, 3, 32'h0033_2211, "R3");
        rd_burst(8'h10, 3, "R6 read data");

        // R4: page select persists into the next transaction
        wr_burst(8'hFF, 1, 32'h09, "R4");
        chk("R4 page output", reg_page, 8'h09);
        wr_burst(8'h20, 2, 32'hBEEF, "R4 persist");
        rd_burst(8'hFF, 1, "R4 page readback");

        // R7: wrap FEh to 00h skips the page register, both directions
        wr_burst(8'hFD, 3, 32'h00C3_B2A1, "R7 write wrap");
        chk("R7 page unchanged", reg_page, 8'h09);
        rd_burst(8'hFD, 3, "R7 read wrap");

        // R8: protected registers read as zero
        rd_burst(8'hF2, 2, "R8 protected read");

        // R5: unmapped page, writes dropped and reads zero
        wr_burst(8'hFF, 1, 32'h05, "R5");
        wr_burst(8'h40, 2, 32'h7766, "R5 unmapped");
        rd_burst(8'h40, 2, "R5 unmapped read");

        // page write and next byte in the same burst (R4, R7)
        wr_burst(8'hFF, 2, 32'h5A11, "R4 page+data");
        chk("R4 page after burst", reg_page, 8'h11);
        rd_burst(8'h00, 1, "R7 new page read");

        // R9: STOP in mid-byte aborts with no write
        bus_start();
        send_byte({DEV_HI, strap, 1'b0}, ack);
        send_byte(8'h30, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        tick(20);
        chk("R9 abort no write", exp_wr.size(), 0);
        chk("R9 idle after stop", sda_oe, 0);
        wr_burst(8'h31, 1, 32'h44, "R9 recover");

        // R10: slower bus rate
        q = 25;
        wr_burst(8'h50, 2, 32'h9988, "R10 slow");
        rd_burst(8'h50, 2, "R10 slow read");
        q = 10;

        // R1: new strap value is honoured
        strap = 2'b01;
        tick(5);
        wr_burst(8'h60, 1, 32'h12, "R1 strap");

        tick(50);
        chk("R3 all writes seen", exp_wr.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        tick(180000);
        nvec++;
        nerr++;
        $display("FAIL R10 watchdog act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule